// File: doc/BRIEF.md
# Integer Execute Unit with Trapping-Overflow Detect

This block is the integer execute stage of a 32-bit load-store RISC pipeline. Each cycle it takes the instruction word together with the two register values read for it. The first register value, selected by bits [25:21], is called `a`. The second, selected by bits [20:16], is called `b`. From these it forms a result, a signed-overflow flag and an illegal-operation flag. All three are registered, so they appear one clock after the inputs are presented.

The unit covers the following operations, in register-register and immediate forms:

- add and subtract
- bitwise logic
- the signed and unsigned less-than compares
- constant and variable shifts
- load-upper-immediate

Each immediate is widened by the rule for its class. Arithmetic and compare immediates are sign-extended, and this includes the non-trapping add. Logical immediates are zero-extended. The overflow flag feeds the core's trap logic and rises only for the trapping add, subtract and add-immediate. Multiply, divide, the register file and the handling of traps belong to other blocks.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `ovf` and `illegal` are all zero. Outside reset, each output shows the effect of the inputs sampled at the previous rising clock edge.
- R2: With opcode 0, the funct field [5:0] selects the arithmetic. Funct 32 and 33 give `a + b`, and funct 34 and 35 give `a - b`, each wrapping modulo 2^32.
- R3: `ovf` is 1 only when the true signed result does not fit in 32 bits, and only for three instructions: funct 32, funct 34 and opcode 8. Funct 33, funct 35 and opcode 9 never raise it, and no other instruction does either.
- R4: With opcode 0, funct 36, 37, 38 and 39 give `a & b`, `a | b`, `a ^ b` and `~(a | b)` respectively.
- R5: Opcodes 12, 13 and 14 AND, OR and XOR `a` with the zero-extended immediate [15:0].
- R6: Opcodes 8 and 9 add the sign-extended immediate [15:0] to `a`.
- R7: Funct 42 writes 1 when `a < b` as two's complement and 0 otherwise. Funct 43 does the same comparing unsigned.
- R8: Opcode 10 compares `a` with the sign-extended immediate as signed values, and opcode 11 compares the same two values as unsigned. Each writes 1 or 0.
- R9: Funct 0, 2 and 3 shift `b` left logical, right logical and right arithmetic, by the amount in instruction bits [10:6].
- R10: Funct 4, 6 and 7 shift `b` the same three ways, by the low 5 bits of `a`.
- R11: Opcode 15 places immediate [15:0] in result [31:16] and clears result [15:0].
- R12: Any other opcode, or any other funct under opcode 0, gives `result` 0, `ovf` 0 and `illegal` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word |
| a | input | 32 | First source register value |
| b | input | 32 | Second source register value |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered signed-overflow flag for trapping forms |
| illegal | output | 1 | Registered unrecognised-encoding flag |

## Verification
The hardest case to reach is overflow on a subtract whose second operand is the most negative number. The sign of that operand cannot be inverted in 32 bits, so the sign test on it is easy to get wrong. The stimulus drives 0 minus 0x80000000 and expects overflow. It also drives the same operand pairs through the trapping and non-trapping forms side by side. The sums are then identical, and only the flag may differ.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_ADDIU = 6'd9;
    localparam logic [5:0] OPC_SLTI  = 6'd10;
    localparam logic [5:0] OPC_SLTIU = 6'd11;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_XORI  = 6'd14;
    localparam logic [5:0] OPC_LUI   = 6'd15;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA, K_LUI, K_NONE
    } exec_kind_e;

    typedef struct packed {
        exec_kind_e kind;
        logic       use_imm;    // second operand from immediate
        logic       imm_zext;   // zero- rather than sign-extend
        logic       var_amt;    // shift amount from register a
        logic       trap_ovf;   // overflow may be reported
        logic       bad;        // encoding not recognised
    } exec_ctl_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [31:0] instr,
    output exec_ctl_t   ctl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        ctl = '{kind: K_NONE, use_imm: 1'b0, imm_zext: 1'b0,
                var_amt: 1'b0, trap_ovf: 1'b0, bad: 1'b0};
        unique case (opc)
            OPC_RTYPE: begin
                unique case (fn)
                    FN_ADD:  begin ctl.kind = K_ADD; ctl.trap_ovf = 1'b1; end
                    FN_ADDU: ctl.kind = K_ADD;
                    FN_SUB:  begin ctl.kind = K_SUB; ctl.trap_ovf = 1'b1; end
                    FN_SUBU: ctl.kind = K_SUB;
                    FN_AND:  ctl.kind = K_AND;
                    FN_OR:   ctl.kind = K_OR;
                    FN_XOR:  ctl.kind = K_XOR;
                    FN_NOR:  ctl.kind = K_NOR;
                    FN_SLT:  ctl.kind = K_SLT;
                    FN_SLTU: ctl.kind = K_SLTU;
                    FN_SLL:  ctl.kind = K_SLL;
                    FN_SRL:  ctl.kind = K_SRL;
                    FN_SRA:  ctl.kind = K_SRA;
                    FN_SLLV: begin ctl.kind = K_SLL; ctl.var_amt = 1'b1; end
                    FN_SRLV: begin ctl.kind = K_SRL; ctl.var_amt = 1'b1; end
                    FN_SRAV: begin ctl.kind = K_SRA; ctl.var_amt = 1'b1; end
                    default: ctl.bad = 1'b1;
                endcase
            end
            OPC_ADDI:  begin ctl.kind = K_ADD;  ctl.use_imm = 1'b1; ctl.trap_ovf = 1'b1; end
            OPC_ADDIU: begin ctl.kind = K_ADD;  ctl.use_imm = 1'b1; end
            OPC_SLTI:  begin ctl.kind = K_SLT;  ctl.use_imm = 1'b1; end
            OPC_SLTIU: begin ctl.kind = K_SLTU; ctl.use_imm = 1'b1; end
            OPC_ANDI:  begin ctl.kind = K_AND;  ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1; end
            OPC_ORI:   begin ctl.kind = K_OR;   ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1; end
            OPC_XORI:  begin ctl.kind = K_XOR;  ctl.use_imm = 1'b1; ctl.imm_zext = 1'b1; end
            OPC_LUI:   ctl.kind = K_LUI;
            default:   ctl.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         sovf
);
    logic [W-1:0] y_eff;

    always_comb begin
        y_eff = do_sub ? ~y : y;
        sum   = x + y_eff + {{(W-1){1'b0}}, do_sub};
        // same-sign inputs, differing result sign
        sovf  = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end

    // R3: flag agrees with a sign-extended wide computation
    logic [W:0] wide_ref;
    always_comb begin
        wide_ref = do_sub ? ({x[W-1], x} - {y[W-1], y})
                          : ({x[W-1], x} + {y[W-1], y});
        a_ovf_wide_r3: assert (sovf == (wide_ref[W] != wide_ref[W-1]));
    end
endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  logic           go_left,
    input  logic           arith,
    output logic [W-1:0]   out
);
    always_comb begin
        if (go_left)
            out = val << amt;
        else if (arith)
            out = W'($signed(val) >>> amt);
        else
            out = val >> amt;
    end

    // R9: a zero amount passes the value through
    always_comb begin
        if (amt == '0)
            a_zero_shift_r9: assert (out == val);
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic            illegal
);
    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            ovf;
        logic            bad;
    } out_t;

    exec_ctl_t       ctl;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] as_sum;
    logic            as_ovf;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] sh_out;
    out_t            nxt_d;
    out_t            cur_q;

    int_exec_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    always_comb begin
        imm_ext = ctl.imm_zext ? {{(XLEN-16){1'b0}}, instr[15:0]}
                               : {{(XLEN-16){instr[15]}}, instr[15:0]};
        opnd_b  = ctl.use_imm ? imm_ext : b;
        sh_amt  = ctl.var_amt ? a[SHW-1:0] : SHW'(instr[10:6]);
    end

    int_exec_addsub #(.W(XLEN)) u_as (
        .x      (a),
        .y      (opnd_b),
        .do_sub (ctl.kind == K_SUB),
        .sum    (as_sum),
        .sovf   (as_ovf)
    );

    int_exec_shift #(.W(XLEN), .SHW(SHW)) u_sh (
        .val     (b),
        .amt     (sh_amt),
        .go_left (ctl.kind == K_SLL),
        .arith   (ctl.kind == K_SRA),
        .out     (sh_out)
    );

    always_comb begin
        nxt_d = '0;
        unique case (ctl.kind)
            K_ADD, K_SUB: nxt_d.res = as_sum;
            K_AND:  nxt_d.res = a & opnd_b;
            K_OR:   nxt_d.res = a | opnd_b;
            K_XOR:  nxt_d.res = a ^ opnd_b;
            K_NOR:  nxt_d.res = ~(a | opnd_b);
            K_SLT:  nxt_d.res = XLEN'($signed(a) < $signed(opnd_b));
            K_SLTU: nxt_d.res = XLEN'(a < opnd_b);
            K_SLL, K_SRL, K_SRA: nxt_d.res = sh_out;
            K_LUI:  nxt_d.res = {instr[15:0], {(XLEN-16){1'b0}}};
            default: nxt_d.res = '0;
        endcase
        nxt_d.ovf = ctl.trap_ovf & as_ovf;
        nxt_d.bad = ctl.bad;
        if (ctl.bad)
            nxt_d.res = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign result  = cur_q.res;
    assign ovf     = cur_q.ovf;
    assign illegal = cur_q.bad;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.trap_ovf |=> !ovf);

    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0 && !ovf));

    p_lui_low_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.kind == K_LUI) |=> (result[15:0] == 16'h0));

    p_compare_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.kind == K_SLT || ctl.kind == K_SLTU) |=> (result[XLEN-1:1] == '0));
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        ovf;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    int_exec_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .instr   (instr),
        .a       (a),
        .b       (b),
        .result  (result),
        .ovf     (ovf),
        .illegal (illegal)
    );

    typedef struct packed {
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [4:0]  sh;
        logic [15:0] imm;
        logic [31:0] va;
        logic [31:0] vb;
        logic [31:0] res;
        logic        ovf;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        // R2 add / sub
        '{6'd0, 6'd32, 5'd0, 16'h0, 32'd5, 32'd7, 32'd12, 1'b0, 1'b0, 4'd2},
        '{6'd0, 6'd34, 5'd0, 16'h0, 32'd3, 32'd5, 32'hFFFFFFFE, 1'b0, 1'b0, 4'd2},
        // R3 trapping vs non-trapping
        '{6'd0, 6'd32, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b1, 1'b0, 4'd3},
        '{6'd0, 6'd33, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b0, 1'b0, 4'd3},
        '{6'd0, 6'd34, 5'd0, 16'h0, 32'h80000000, 32'd1, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3},
        '{6'd0, 6'd35, 5'd0, 16'h0, 32'h80000000, 32'd1, 32'h7FFFFFFF, 1'b0, 1'b0, 4'd3},
        '{6'd0, 6'd34, 5'd0, 16'h0, 32'h0, 32'h80000000, 32'h80000000, 1'b1, 1'b0, 4'd3},
        '{6'd8, 6'd0, 5'd0, 16'h0001, 32'h7FFFFFFF, 32'h0, 32'h80000000, 1'b1, 1'b0, 4'd3},
        '{6'd9, 6'd0, 5'd0, 16'h0001, 32'h7FFFFFFF, 32'h0, 32'h80000000, 1'b0, 1'b0, 4'd3},
        '{6'd8, 6'd0, 5'd0, 16'hFFFF, 32'h80000000, 32'h0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3},
        // R4 register logic
        '{6'd0, 6'd36, 5'd0, 16'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0, 4'd4},
        '{6'd0, 6'd37, 5'd0, 16'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0, 4'd4},
        '{6'd0, 6'd38, 5'd0, 16'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 1'b0, 4'd4},
        '{6'd0, 6'd39, 5'd0, 16'h0, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F, 1'b0, 1'b0, 4'd4},
        // R5 immediate logic, zero-extended
        '{6'd12, 6'd0, 5'd0, 16'h8001, 32'hFFFFFFFF, 32'h0, 32'h00008001, 1'b0, 1'b0, 4'd5},
        '{6'd13, 6'd0, 5'd0, 16'h8000, 32'h00000001, 32'h0, 32'h00008001, 1'b0, 1'b0, 4'd5},
        '{6'd14, 6'd0, 5'd0, 16'hFFFF, 32'hFFFF0000, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd5},
        // R6 immediate add, sign-extended
        '{6'd8, 6'd0, 5'd0, 16'hFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd6},
        '{6'd9, 6'd0, 5'd0, 16'h8000, 32'h0, 32'h0, 32'hFFFF8000, 1'b0, 1'b0, 4'd6},
        // R7 register compares
        '{6'd0, 6'd42, 5'd0, 16'h0, 32'hFFFFFFFF, 32'd1, 32'd1, 1'b0, 1'b0, 4'd7},
        '{6'd0, 6'd43, 5'd0, 16'h0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b0, 1'b0, 4'd7},
        '{6'd0, 6'd42, 5'd0, 16'h0, 32'd5, 32'd5, 32'd0, 1'b0, 1'b0, 4'd7},
        // R8 immediate compares
        '{6'd10, 6'd0, 5'd0, 16'hFFFF, 32'hFFFFFFFE, 32'h0, 32'd1, 1'b0, 1'b0, 4'd8},
        '{6'd11, 6'd0, 5'd0, 16'hFFFF, 32'd5, 32'h0, 32'd1, 1'b0, 1'b0, 4'd8},
        '{6'd11, 6'd0, 5'd0, 16'h0000, 32'd0, 32'h0, 32'd0, 1'b0, 1'b0, 4'd8},
        // R9 constant shifts
        '{6'd0, 6'd0, 5'd4, 16'h0, 32'h0, 32'h8000000F, 32'h000000F0, 1'b0, 1'b0, 4'd9},
        '{6'd0, 6'd2, 5'd4, 16'h0, 32'h0, 32'h8000000F, 32'h08000000, 1'b0, 1'b0, 4'd9},
        '{6'd0, 6'd3, 5'd4, 16'h0, 32'h0, 32'h8000000F, 32'hF8000000, 1'b0, 1'b0, 4'd9},
        '{6'd0, 6'd3, 5'd31, 16'h0, 32'h0, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd9},
        '{6'd0, 6'd0, 5'd0, 16'h0, 32'h0, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 4'd9},
        // R10 variable shifts, low 5 bits of a
        '{6'd0, 6'd4, 5'd0, 16'h0, 32'h00000024, 32'd1, 32'h00000010, 1'b0, 1'b0, 4'd10},
        '{6'd0, 6'd6, 5'd0, 16'h0, 32'hFFFFFFE1, 32'h80000000, 32'h40000000, 1'b0, 1'b0, 4'd10},
        '{6'd0, 6'd7, 5'd0, 16'h0, 32'h0000003F, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd10},
        // R11 load upper
        '{6'd15, 6'd0, 5'd0, 16'hABCD, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hABCD0000, 1'b0, 1'b0, 4'd11},
        // R12 unrecognised encodings
        '{6'd0, 6'd1, 5'd0, 16'h0, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 1'b1, 4'd12},
        '{6'd63, 6'd0, 5'd0, 16'h1234, 32'h7FFFFFFF, 32'd1, 32'd0, 1'b0, 1'b1, 4'd12},
        '{6'd0, 6'd40, 5'd0, 16'h0, 32'd5, 32'd7, 32'd0, 1'b0, 1'b1, 4'd12}
    };

    function automatic logic [31:0] build(input vec_t v);
        if (v.op == 6'd0)
            return {6'd0, 5'd1, 5'd2, 5'd3, v.sh, v.fn};
        return {v.op, 5'd1, 5'd2, v.imm};
    endfunction

    task automatic check(input int req, input logic [31:0] er,
                         input logic eo, input logic ei);
        n_cmp++;
        if (result !== er || ovf !== eo || illegal !== ei) begin
            n_bad++;
            $display("FAIL R%0d: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
                     req, result, ovf, illegal, er, eo, ei);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        instr = build(v);
        a     = v.va;
        b     = v.vb;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL R1: watchdog expired, got no end, expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs held at zero while reset is low, even with live inputs
        instr = build(VECS[2]);
        a = VECS[2].va;
        b = VECS[2].vb;
        repeat (3) @(posedge clk);
        #1;
        check(1, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: one-cycle latency: output reflects the previous edge only
        apply(VECS[0]);
        @(negedge clk);
        instr = build(VECS[10]);
        a = VECS[10].va;
        b = VECS[10].vb;
        #1;
        check(1, 32'd12, 1'b0, 1'b0);

        // table walk, R2 through R12
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(int'(VECS[i].req), VECS[i].res, VECS[i].ovf, VECS[i].ill);
        end

        // R12 then R3: an illegal encoding leaves nothing behind for the next op
        apply(VECS[35]);
        apply(VECS[3]);
        check(3, 32'h80000000, 1'b0, 1'b0);

        // R1: reset mid-stream clears flagged outputs
        apply(VECS[2]);
        check(3, 32'h80000000, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: shift amount 32 in a wraps to zero
        apply('{6'd0, 6'd4, 5'd0, 16'h0, 32'h00000020, 32'hCAFEF00D,
                32'hCAFEF00D, 1'b0, 1'b0, 4'd10});
        check(10, 32'hCAFEF00D, 1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule